// File: doc/BRIEF.md
# Parallel Flash Program and Erase Sequencer

This block sits on the host side of an asynchronous byte-wide flash device and turns a one-cycle request (operation code, target address, data byte) into the full bus activity needed to alter the array. It first emits the unlock write cycles of the selected operation, with chip-enable and write-enable pulse widths counted in clock cycles from nanosecond parameters. It then reads the target location over and over until the device stops toggling its status bit 6, and reports completion with a one-cycle done pulse and an error flag.

A false stable reading near the end of an internal operation is filtered out. The block only treats the operation as finished after a first pair of equal reads and two further reads that agree with it. A cycle-count timeout ends polling with an error when the bit never settles. After reset the block stays busy for the power-up settling time before it takes any request. It handles one operation at a time.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After reset `busy` stays high and no write-enable pulse is issued for the power-up time (100 µs, 10000 cycles at 10 ns); a `req_start` in that window is ignored; all three strobes are high during and straight after reset.
- R2: With `req_op`=0 (program) the bus carries exactly four writes: data AAh to address 05555h, 55h to 02AAAh, A0h to 05555h, then `req_data` to `req_addr`.
- R3: With `req_op`=1, 2 or 3 (sector, block, chip erase) the bus carries exactly six writes: AAh@05555h, 55h@02AAAh, 80h@05555h, AAh@05555h, 55h@02AAAh, then 30h@`req_addr`, 50h@`req_addr` or 10h@05555h respectively.
- R4: Every write-enable low pulse lasts at least the larger of the write-pulse and data-setup times in cycles (4), with address and data unchanged during it; write-enable stays high at least the pulse-high time (3 cycles) between pulses; chip-enable is low whenever write-enable is low.
- R5: After the last write the block polls with read cycles at `req_addr` (chip enable and output enable low, write enable high); write enable and output enable are never low together.
- R6: Polling ends when three successive read-to-read comparisons of bit 6 of `fl_din` are equal. If the device toggles bit 6 on B reads, done follows read B+4, with `err`=0.
- R7: An equal pair followed by a differing read resets the agreement count, so polling continues: one missed toggle costs exactly one extra read (B+5 reads).
- R8: If bit 6 has not settled once the poll time exceeds the timeout (TMO_NS, rounded up to cycles), polling ends at the end of the current read with `done` and `err` both high.
- R9: A `req_start` while `busy` is high is ignored: no extra bus write is issued.
- R10: `done` is a one-cycle pulse, `busy` is low in the cycle of `done`, and `err` is never high without `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | One-cycle request strobe |
| req_op | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| req_addr | input | AW | Target byte, sector or block address |
| req_data | input | 8 | Byte to program |
| busy | output | 1 | High while powering up or running an operation |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Timeout flag, valid with done |
| fl_addr | output | AW | Flash address bus |
| fl_dout | output | 8 | Flash write data |
| fl_din | input | 8 | Flash read data |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_we_n | output | 1 | Write enable, active low |

## Verification
The assertions assume that `fl_din` is stable while output enable is low, and that the host drives `req_start` only as a clean one-cycle strobe synchronous to the clock. The bench's flash model updates bit 6 only at the rising edge of output enable and holds it between reads. The bench pulses `req_start` at negative clock edges. It also checks the rejection of a second start by deliberately pulsing one mid-operation, and that pulse must leave no trace on the bus.

// File: rtl/flash_ctrl_pkg.sv
package flash_ctrl_pkg;
  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_BLK  = 2'd2,
    OP_CHIP = 2'd3
  } op_e;

  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned per);
    return (ns + per - 1) / per;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_ctrl_pkg::*;
#(
  parameter int unsigned AW = 20
) (
  input  logic [1:0]    op,
  input  logic [2:0]    step,
  input  logic [AW-1:0] tgt_addr,
  input  logic [7:0]    tgt_data,
  output logic [AW-1:0] c_addr,
  output logic [7:0]    c_data,
  output logic          c_last
);
  localparam logic [AW-1:0] A_HI = AW'(15'h5555);
  localparam logic [AW-1:0] A_LO = AW'(15'h2AAA);

  always_comb begin
    c_addr = A_HI;
    c_data = 8'hAA;
    if (op == OP_PROG) begin
      c_last = (step == 3'd3);
      case (step)
        3'd0:    begin c_addr = A_HI;     c_data = 8'hAA;    end
        3'd1:    begin c_addr = A_LO;     c_data = 8'h55;    end
        3'd2:    begin c_addr = A_HI;     c_data = 8'hA0;    end
        default: begin c_addr = tgt_addr; c_data = tgt_data; end
      endcase
    end else begin
      c_last = (step == 3'd5);
      case (step)
        3'd0:    begin c_addr = A_HI; c_data = 8'hAA; end
        3'd1:    begin c_addr = A_LO; c_data = 8'h55; end
        3'd2:    begin c_addr = A_HI; c_data = 8'h80; end
        3'd3:    begin c_addr = A_HI; c_data = 8'hAA; end
        3'd4:    begin c_addr = A_LO; c_data = 8'h55; end
        default: begin
          case (op)
            OP_SECT: begin c_addr = tgt_addr; c_data = 8'h30; end
            OP_BLK:  begin c_addr = tgt_addr; c_data = 8'h50; end
            default: begin c_addr = A_HI;     c_data = 8'h10; end
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/flash_bus_cyc.sv
module flash_bus_cyc #(
  parameter int unsigned AW      = 20,
  parameter int unsigned WR_CYC  = 4,
  parameter int unsigned RD_CYC  = 7,
  parameter int unsigned REC_CYC = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          rd,
  input  logic [AW-1:0] addr_in,
  input  logic [7:0]    wdata,
  output logic          ack,
  output logic [7:0]    rdata,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_dout,
  input  logic [7:0]    fl_din,
  output logic          fl_ce_n,
  output logic          fl_oe_n,
  output logic          fl_we_n
);
  localparam int unsigned CW = $clog2(WR_CYC + RD_CYC + REC_CYC + 1);

  typedef enum logic [1:0] {B_IDLE, B_ACT, B_REC} bst_e;

  bst_e          st, st_nx;
  logic [CW-1:0] cnt, cnt_nx, act_m1;
  logic          rd_q, act_end, rec_end, ld_en, cap_en;
  logic [AW-1:0] a_q;
  logic [7:0]    d_q, r_q;

  assign act_m1  = rd_q ? CW'(RD_CYC - 1) : CW'(WR_CYC - 1);
  assign act_end = (st == B_ACT) && (cnt == act_m1);
  assign rec_end = (st == B_REC) && (cnt == CW'(REC_CYC - 1));
  assign ld_en   = (st == B_IDLE) && go;
  assign cap_en  = act_end && rd_q;

  always_comb begin
    st_nx  = st;
    cnt_nx = cnt + 1'b1;
    case (st)
      B_IDLE: begin
        cnt_nx = '0;
        if (go) st_nx = B_ACT;
      end
      B_ACT: if (act_end) begin st_nx = B_REC; cnt_nx = '0; end
      default: if (rec_end) begin st_nx = B_IDLE; cnt_nx = '0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= B_IDLE;
      cnt  <= '0;
      rd_q <= 1'b0;
      a_q  <= '0;
      d_q  <= '0;
      r_q  <= '0;
    end else begin
      st  <= st_nx;
      cnt <= cnt_nx;
      if (ld_en) begin
        rd_q <= rd;
        a_q  <= addr_in;
        d_q  <= wdata;
      end
      if (cap_en) r_q <= fl_din;
    end
  end

  assign ack     = rec_end;
  assign rdata   = r_q;
  assign fl_addr = a_q;
  assign fl_dout = d_q;
  assign fl_ce_n = (st != B_ACT);
  assign fl_we_n = !((st == B_ACT) && !rd_q);
  assign fl_oe_n = !((st == B_ACT) && rd_q);
endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import flash_ctrl_pkg::*;
#(
  parameter int unsigned AW       = 20,
  parameter int unsigned CLK_NS   = 10,
  parameter int unsigned TWP_NS   = 40,
  parameter int unsigned TWPH_NS  = 30,
  parameter int unsigned TDS_NS   = 30,
  parameter int unsigned TACC_NS  = 70,
  parameter int unsigned PWRUP_NS = 100000,
  parameter int unsigned TMO_NS   = 100000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_start,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_dout,
  input  logic [7:0]    fl_din,
  output logic          fl_ce_n,
  output logic          fl_oe_n,
  output logic          fl_we_n
);
  localparam int unsigned WR_CYC  = umax(ns2cyc(TWP_NS, CLK_NS), ns2cyc(TDS_NS, CLK_NS));
  localparam int unsigned RD_CYC  = umax(ns2cyc(TACC_NS, CLK_NS), 1);
  localparam int unsigned REC_CYC = umax(ns2cyc(TWPH_NS, CLK_NS), 1);
  localparam int unsigned PWR_CYC = umax(ns2cyc(PWRUP_NS, CLK_NS), 1);
  localparam int unsigned TMO_CYC = umax(ns2cyc(TMO_NS, CLK_NS), 1);
  localparam int unsigned PW      = $clog2(PWR_CYC + 1);
  localparam int unsigned TW      = $clog2(TMO_CYC + 1);

  typedef enum logic [1:0] {S_PWR, S_IDLE, S_WR, S_POLL} st_e;

  logic          rs_q1, rs_n;
  st_e           st, st_nx;
  logic [2:0]    step, step_nx;
  logic [1:0]    op_q, mcnt, mcnt_nx;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic [PW-1:0] pcnt;
  logic [TW-1:0] tcnt;
  logic          first, first_nx, prev6, prev6_nx, done_nx, err_nx, cap_en;
  logic          tmo_hit, bus_go, bus_rd, bus_ack;
  logic [AW-1:0] c_addr;
  logic [7:0]    c_data, rdata;
  logic          c_last;

  // reset asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_n  <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_n  <= rs_q1;
    end
  end

  flash_cmd_seq #(.AW(AW)) u_seq (
    .op(op_q), .step(step), .tgt_addr(addr_q), .tgt_data(data_q),
    .c_addr(c_addr), .c_data(c_data), .c_last(c_last)
  );

  assign bus_go = (st == S_WR) || (st == S_POLL);
  assign bus_rd = (st == S_POLL);

  flash_bus_cyc #(.AW(AW), .WR_CYC(WR_CYC), .RD_CYC(RD_CYC), .REC_CYC(REC_CYC)) u_bus (
    .clk(clk), .rst_n(rs_n), .go(bus_go), .rd(bus_rd),
    .addr_in(bus_rd ? addr_q : c_addr), .wdata(c_data),
    .ack(bus_ack), .rdata(rdata),
    .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_din(fl_din),
    .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
  );

  assign tmo_hit = (tcnt >= TW'(TMO_CYC));
  assign cap_en  = (st == S_IDLE) && req_start;

  always_comb begin
    st_nx    = st;
    step_nx  = step;
    first_nx = first;
    prev6_nx = prev6;
    mcnt_nx  = mcnt;
    done_nx  = 1'b0;
    err_nx   = 1'b0;
    case (st)
      S_PWR:  if (pcnt == PW'(PWR_CYC - 1)) st_nx = S_IDLE;
      S_IDLE: if (req_start) begin st_nx = S_WR; step_nx = '0; end
      S_WR: if (bus_ack) begin
        if (c_last) begin
          st_nx    = S_POLL;
          first_nx = 1'b1;
          mcnt_nx  = '0;
        end else begin
          step_nx = step + 1'b1;
        end
      end
      default: if (bus_ack) begin
        prev6_nx = rdata[6];
        first_nx = 1'b0;
        if (!first && (rdata[6] == prev6)) mcnt_nx = mcnt + 1'b1;
        else                               mcnt_nx = '0;
        if (!first && (rdata[6] == prev6) && (mcnt == 2'd2)) begin
          st_nx   = S_IDLE;
          done_nx = 1'b1;
        end else if (tmo_hit) begin
          st_nx   = S_IDLE;
          done_nx = 1'b1;
          err_nx  = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      st     <= S_PWR;
      step   <= '0;
      op_q   <= '0;
      addr_q <= '0;
      data_q <= '0;
      pcnt   <= '0;
      tcnt   <= '0;
      first  <= 1'b0;
      prev6  <= 1'b0;
      mcnt   <= '0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      st    <= st_nx;
      step  <= step_nx;
      first <= first_nx;
      prev6 <= prev6_nx;
      mcnt  <= mcnt_nx;
      done  <= done_nx;
      err   <= err_nx;
      if (st == S_PWR) pcnt <= pcnt + 1'b1;
      if (cap_en) begin
        op_q   <= req_op;
        addr_q <= req_addr;
        data_q <= req_data;
      end
      if (st != S_POLL)  tcnt <= '0;
      else if (!tmo_hit) tcnt <= tcnt + 1'b1;
    end
  end

  assign busy = (st != S_IDLE);
endmodule

// File: rtl/flash_prog_chk.sv
module flash_prog_chk #(
  parameter int unsigned AW      = 20,
  parameter int unsigned WR_CYC  = 4,
  parameter int unsigned REC_CYC = 3,
  parameter int unsigned PWR_CYC = 10000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic [AW-1:0] fl_addr,
  input logic [7:0]    fl_dout,
  input logic          fl_ce_n,
  input logic          fl_oe_n,
  input logic          fl_we_n
);
  localparam int unsigned PW = $clog2(PWR_CYC + 1);
  localparam int unsigned GW = $clog2(WR_CYC + REC_CYC + 2);

  logic [PW-1:0] pwr_cnt;
  logic [GW-1:0] lo_cnt, hi_cnt;
  logic          seen_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_cnt <= '0;
      lo_cnt  <= '0;
      hi_cnt  <= '0;
      seen_wr <= 1'b0;
    end else begin
      if (pwr_cnt != PW'(PWR_CYC)) pwr_cnt <= pwr_cnt + 1'b1;
      if (!fl_we_n) begin
        seen_wr <= 1'b1;
        hi_cnt  <= '0;
        if (lo_cnt != '1) lo_cnt <= lo_cnt + 1'b1;
      end else begin
        lo_cnt <= '0;
        if (hi_cnt != '1) hi_cnt <= hi_cnt + 1'b1;
      end
    end
  end

  // R1
  pwrup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_cnt < PW'(PWR_CYC)) |-> fl_we_n);
  // R4
  we_low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fl_we_n) && (lo_cnt != '0)) |-> (lo_cnt >= GW'(WR_CYC)));
  // R4
  we_high_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(fl_we_n) && seen_wr) |-> (hi_cnt >= GW'(REC_CYC)));
  // R4
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dout)));
  // R4
  we_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> !fl_ce_n);
  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_we_n && !fl_oe_n));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R10
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
endmodule

bind flash_prog_ctrl flash_prog_chk #(
  .AW(AW), .WR_CYC(WR_CYC), .REC_CYC(REC_CYC), .PWR_CYC(PWR_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_ce_n(fl_ce_n),
  .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
);

// File: tb/test_flash_prog_ctrl.sv
module test_flash_prog_ctrl;
  localparam int AW = 20;

  logic          clk, rst_n, req_start;
  logic [1:0]    req_op;
  logic [AW-1:0] req_addr;
  logic [7:0]    req_data;
  logic          busy, done, err;
  logic [AW-1:0] fl_addr;
  logic [7:0]    fl_dout, fl_din;
  logic          fl_ce_n, fl_oe_n, fl_we_n;

  flash_prog_ctrl #(.AW(AW), .TMO_NS(20000)) i_flash_prog_ctrl (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .busy(busy), .done(done), .err(err),
    .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_din(fl_din),
    .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  logic [AW+7:0] exp_q[$];

  // flash model state
  logic          t6;
  int            busy_left, model_b, glitch_at, reads, writes;
  logic [AW-1:0] tgt;
  logic          we_prev, oe_prev;
  int            lo_n, hi_n;
  logic [AW-1:0] wa;
  logic [7:0]    wd;

  assign fl_din = {1'b0, t6, 6'b010101};

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  // monitor and flash model, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      we_prev = 1'b1; oe_prev = 1'b1; lo_n = 0; hi_n = 100;
    end else begin
      if (we_prev && !fl_we_n) begin
        chk(hi_n >= 3, "R4 we high gap", hi_n, 3);
        wa = fl_addr; wd = fl_dout; lo_n = 0;
      end
      if (!fl_we_n) begin
        lo_n++;
        chk(fl_addr == wa && fl_dout == wd, "R4 write hold", {fl_addr, fl_dout}, {wa, wd});
      end else hi_n++;
      if (!we_prev && fl_we_n) begin
        hi_n = 1;
        writes++;
        chk(lo_n >= 4, "R4 we low width", lo_n, 4);
        if (exp_q.size() == 0) chk(0, "R9 unexpected write", {wa, wd}, 0);
        else begin
          logic [AW+7:0] e;
          e = exp_q.pop_front();
          chk({wa, wd} == e, "R2 R3 write sequence", {wa, wd}, e);
          if (exp_q.size() == 0) busy_left = model_b;
        end
      end
      if (oe_prev && !fl_oe_n)
        chk(fl_addr == tgt && fl_we_n, "R5 poll address", fl_addr, tgt);
      if (!oe_prev && fl_oe_n) begin
        reads++;
        if (busy_left > 0 && reads != glitch_at) begin
          t6 = ~t6;
          busy_left--;
        end
      end
      we_prev = fl_we_n;
      oe_prev = fl_oe_n;
    end
  end

  task automatic push_seq(input logic [1:0] op, input logic [AW-1:0] a, input logic [7:0] d);
    exp_q.push_back({20'h05555, 8'hAA});
    exp_q.push_back({20'h02AAA, 8'h55});
    if (op == 2'd0) begin
      exp_q.push_back({20'h05555, 8'hA0});
      exp_q.push_back({a, d});
    end else begin
      exp_q.push_back({20'h05555, 8'h80});
      exp_q.push_back({20'h05555, 8'hAA});
      exp_q.push_back({20'h02AAA, 8'h55});
      case (op)
        2'd1:    exp_q.push_back({a, 8'h30});
        2'd2:    exp_q.push_back({a, 8'h50});
        default: exp_q.push_back({20'h05555, 8'h10});
      endcase
    end
  endtask

  task automatic run_op(input string req, input logic [1:0] op, input logic [AW-1:0] a,
                        input logic [7:0] d, input int b, input int g, input int exp_reads,
                        input bit exp_err, input bit extra);
    int n_wr;
    int guard;
    bit got_err;
    n_wr = (op == 2'd0) ? 4 : 6;
    push_seq(op, a, d);
    model_b = b; glitch_at = g; reads = 0; writes = 0; tgt = a; busy_left = 0;
    @(negedge clk);
    req_op = op; req_addr = a; req_data = d; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    if (extra) begin
      repeat (30) @(negedge clk);
      req_op = 2'd3; req_addr = 20'h00000; req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
    end
    guard = 0;
    while (!done && guard < 20000) begin @(negedge clk); guard++; end
    got_err = err;
    chk(done, {req, " done seen"}, done, 1);
    chk(got_err == exp_err, {req, " err flag"}, got_err, exp_err);
    if (!exp_err) chk(reads == exp_reads, {req, " poll reads"}, reads, exp_reads);
    chk(writes == n_wr && exp_q.size() == 0, {req, " write count"}, writes, n_wr);
    @(negedge clk);
    chk(!done && !busy, "R10 done pulse single", {done, busy}, 0);
  endtask

  initial begin
    rst_n = 1'b0; req_start = 1'b0; req_op = 2'd0; req_addr = '0; req_data = '0;
    t6 = 1'b0; busy_left = 0; model_b = 0; glitch_at = -1; reads = 0; writes = 0; tgt = '0;
    repeat (5) @(negedge clk);
    chk(fl_we_n && fl_oe_n && fl_ce_n, "R1 strobes in reset", {fl_we_n, fl_oe_n, fl_ce_n}, 3'b111);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy == 1'b1, "R1 busy after reset", busy, 1);
    chk(fl_we_n && fl_oe_n && fl_ce_n, "R1 strobes after reset", {fl_we_n, fl_oe_n, fl_ce_n}, 3'b111);
    req_op = 2'd0; req_addr = 20'h00123; req_data = 8'h77; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    repeat (9900) @(negedge clk);
    chk(busy == 1'b1, "R1 busy in power-up window", busy, 1);
    chk(writes == 0, "R1 no write in power-up window", writes, 0);
    while (busy) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(writes == 0 && fl_ce_n, "R1 start during power-up ignored", writes, 0);

    run_op("R2 R6 program", 2'd0, 20'h12345, 8'h3C, 5, -1, 9, 1'b0, 1'b0);
    run_op("R9 program with second start", 2'd0, 20'h00F00, 8'hA5, 4, -1, 8, 1'b0, 1'b1);
    run_op("R7 false match", 2'd0, 20'h7FFFF, 8'h01, 6, 3, 11, 1'b0, 1'b0);
    run_op("R3 sector erase", 2'd1, 20'h45678, 8'h00, 3, -1, 7, 1'b0, 1'b0);
    run_op("R3 block erase", 2'd2, 20'hABCDE, 8'h00, 2, -1, 6, 1'b0, 1'b0);
    run_op("R3 R6 chip erase", 2'd3, 20'h11111, 8'h00, 0, -1, 4, 1'b0, 1'b0);
    run_op("R8 timeout", 2'd0, 20'h00042, 8'h99, 1000000, -1, 0, 1'b1, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule